// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Zero Bus Turnaround

This block is a synthesizable behavioural model of a single-port synchronous SRAM. It is built so that reads and writes can follow each other in any order on a shared data bus with no idle cycles. A read command returns its word in the bus slot two active clock edges after the command. A write command is captured together with its address and byte enables, and its data is taken from the bus two active edges later. Both kinds of access therefore use the bus at the same pipeline depth.

Because a write's data arrives late, the write sits in a two-stage command pipeline until its data is on the bus. A read issued right behind a write to the same word has to see that write's bytes, so the read path forwards them lane by lane from the bus. A burst-advance input generates follow-on addresses inside an aligned group of four words, in either linear or interleaved order. A clock-enable input freezes the whole block for a cycle. The memory depth is a parameter, kept small for simulation.

Top module: `nb_sram`

## Requirements
- R1: A command with `wr_n`=0, with the device selected and `adv`=0, is a write. Its address and `bw_n` are captured at an active edge, and its data is sampled from `dq` at the second active edge after that. The block does not drive `dq` during that slot.
- R2: A command with `wr_n`=1, with the device selected and `adv`=0, is a read. The addressed word is driven on `dq` during the clock cycle that ends at the second active edge after the command.
- R3: Commands may follow each other back to back in any order. A read issued one active edge after a write to the same address returns the written bytes.
- R4: `bw_n[0]` low lets a write update bits 8:0, and `bw_n[1]` low lets it update bits 17:9. A lane whose enable is high keeps its old contents.
- R5: While `oe_n` is high, `dq` is high impedance. `oe_n` has no effect on writes.
- R6: The device is selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A deselect command performs no access and leaves `dq` high impedance in its slot. Commands already in the pipeline still complete.
- R7: With `adv`=1, the external address, chip enables and `wr_n` are ignored, and the previous operation type (read, write or deselect) repeats. With `lin_order`=1, the k-th advance uses low address bits (start + k) mod 4, and the upper bits stay those of the start address.
- R8: With `lin_order`=0, the k-th advance uses low address bits start XOR (k mod 4).
- R9: An edge with `cke_n`=1 changes no pipeline stage, burst state or memory word. The bus slot in progress, and the read data driven in it, extends by one cycle.
- R10: After reset, the pipeline holds no commands, `dq` is high impedance, and the remembered operation type is deselect, so an advance issued before any command performs no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_n | input | 1 | Clock enable, active low; high stalls the block |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Low for write, high for read |
| adv | input | 1 | Burst advance; high continues the previous operation |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| bw_n | input | LANES (2) | Byte-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (6) | Word address |
| dq | inout | LANES*LANE_W (18) | Bidirectional data bus |

## Verification
Two functions can land on the same edge. When a read follows a write to the same word, the write commits its data from the bus at the very edge where the read captures its result, so the read must take the bus bytes through forwarding rather than the stale array word. The bench provokes this by reusing the previous address about one time in three during random traffic, with random byte enables and random stalls. It also runs directed write-then-read pairs with partial lanes. A behavioural reference that applies commands in program order predicts each read slot, so a read that misses the pending bytes shows up as a compare mismatch. A stall that lands inside such a slot must hold both the commit and the forwarded result.

// File: rtl/nb_sram_pkg.sv
package nb_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  localparam int unsigned BURST_W = 2;

  // Low address bits for a burst beat: linear adds, interleaved flips bits.
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               linear
  );
    logic [BURST_W-1:0] sum;
    sum = start + step;
    burst_lo = linear ? sum : (start ^ step);
  endfunction

endpackage

// File: rtl/nb_burst_ctl.sv
module nb_burst_ctl
  import nb_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              adv,
  input  logic              sel,
  input  logic              wr_n,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_bw_n
);

  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d, step_nx;
  op_e                op_q, op_d;

  // command decode
  always_comb begin
    step_nx  = cnt_q + 1'b1;
    cmd_bw_n = bw_n;
    if (adv) begin
      cmd_op                  = op_q;
      cmd_addr                = base_q;
      cmd_addr[BURST_W-1:0]   = burst_lo(base_q[BURST_W-1:0], step_nx, lin_order);
    end else if (sel) begin
      cmd_op   = wr_n ? OP_RD : OP_WR;
      cmd_addr = addr;
    end else begin
      cmd_op   = OP_NONE;
      cmd_addr = addr;
    end
  end

  // next state
  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    if (adv) begin
      cnt_d = step_nx;
    end else begin
      base_d = addr;
      cnt_d  = '0;
      op_d   = cmd_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
    end else if (advance) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
    end
  end

  // R7
  burst_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && adv) |=> (op_q == $past(op_q)));

endmodule

// File: rtl/nb_cmd_pipe.sv
module nb_cmd_pipe
  import nb_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_bw_n,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_bw_n
);

  op_e               s1_op_q, s1_op_d, s2_op_q, s2_op_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d;
  logic [LANES-1:0]  s1_bw_q, s1_bw_d, s2_bw_q, s2_bw_d;

  always_comb begin
    s1_op_d   = s1_op_q;
    s1_addr_d = s1_addr_q;
    s1_bw_d   = s1_bw_q;
    s2_op_d   = s2_op_q;
    s2_addr_d = s2_addr_q;
    s2_bw_d   = s2_bw_q;
    if (advance) begin
      s1_op_d   = in_op;
      s1_addr_d = in_addr;
      s1_bw_d   = in_bw_n;
      s2_op_d   = s1_op_q;
      s2_addr_d = s1_addr_q;
      s2_bw_d   = s1_bw_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= OP_NONE;
      s1_addr_q <= '0;
      s1_bw_q   <= '1;
      s2_op_q   <= OP_NONE;
      s2_addr_q <= '0;
      s2_bw_q   <= '1;
    end else begin
      s1_op_q   <= s1_op_d;
      s1_addr_q <= s1_addr_d;
      s1_bw_q   <= s1_bw_d;
      s2_op_q   <= s2_op_d;
      s2_addr_q <= s2_addr_d;
      s2_bw_q   <= s2_bw_d;
    end
  end

  assign s1_op   = s1_op_q;
  assign s1_addr = s1_addr_q;
  assign s2_op   = s2_op_q;
  assign s2_addr = s2_addr_q;
  assign s2_bw_n = s2_bw_q;

  // R9
  pipe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(s2_op_q) && $stable(s2_addr_q) && $stable(s1_op_q)));

  // R1
  pipe_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (s2_op_q == $past(s1_op_q) && s2_addr_q == $past(s1_addr_q)));

endmodule

// File: rtl/nb_store.sv
module nb_store
  import nb_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  op_e               s1_op,
  input  logic [ADDR_W-1:0] s1_addr,
  input  op_e               s2_op,
  input  logic [ADDR_W-1:0] s2_addr,
  input  logic [LANES-1:0]  s2_bw_n,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word, rd_q, rd_d;
  logic              we, hit;

  assign we  = advance && (s2_op == OP_WR);
  assign hit = (s2_op == OP_WR) && (s2_addr == s1_addr);

  // array word with pending bus bytes merged in
  always_comb begin
    rd_word = mem[s1_addr];
    for (int l = 0; l < LANES; l++) begin
      if (hit && !s2_bw_n[l]) begin
        rd_word[l*LANE_W +: LANE_W] = wdata_in[l*LANE_W +: LANE_W];
      end
    end
    rd_d = (advance && s1_op == OP_RD) ? rd_word : rd_q;
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && !s2_bw_n[l]) begin
        mem[s2_addr][l*LANE_W +: LANE_W] <= wdata_in[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

  // R3
  fwd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && s1_op == OP_RD && s2_op == OP_WR && s1_addr == s2_addr && !s2_bw_n[0])
    |=> (rd_q[LANE_W-1:0] == $past(wdata_in[LANE_W-1:0])));

endmodule

// File: rtl/nb_sram.sv
module nb_sram
  import nb_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              wr_n,
  input  logic              adv,
  input  logic              lin_order,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dq
);

  logic rst_meta_q, rst_sync_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_core_n = rst_sync_q;

  logic              advance, sel, drive_en;
  op_e               cmd_op, s1_op, s2_op;
  logic [ADDR_W-1:0] cmd_addr, s1_addr, s2_addr;
  logic [LANES-1:0]  cmd_bw_n, s2_bw_n;
  logic [DATA_W-1:0] rdata, wdata_in;

  assign advance = !cke_n;
  assign sel     = !ce_a_n && ce_b && !ce_c_n;

  nb_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk(clk), .rst_n(rst_core_n), .advance(advance), .adv(adv), .sel(sel),
    .wr_n(wr_n), .lin_order(lin_order), .addr(addr), .bw_n(bw_n),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bw_n(cmd_bw_n)
  );

  nb_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_core_n), .advance(advance),
    .in_op(cmd_op), .in_addr(cmd_addr), .in_bw_n(cmd_bw_n),
    .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n)
  );

  nb_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_core_n), .advance(advance),
    .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n),
    .wdata_in(wdata_in), .rdata(rdata)
  );

  assign drive_en = (s2_op == OP_RD) && !oe_n;
  assign dq       = drive_en ? rdata : {DATA_W{1'bz}};
  assign wdata_in = dq;

  // R6
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (advance && s1_op == OP_NONE) |=> !drive_en);

endmodule

// File: tb/nb_sram_tb.sv
`timescale 1ns/100ps
module nb_sram_tb;

  localparam int AW = 6;
  localparam int DW = 18;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, cke_n, ce_a_n, ce_b, ce_c_n, wr_n, adv, lin_order, oe_n;
  logic [1:0]    bw_n;
  logic [AW-1:0] addr;
  wire  [DW-1:0] dq;
  logic          drv_en;
  logic [DW-1:0] drv_val;

  assign dq = drv_en ? drv_val : {DW{1'bz}};

  always #2 clk = ~clk;

  nb_sram u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce_a_n(ce_a_n), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .wr_n(wr_n), .adv(adv), .lin_order(lin_order),
    .bw_n(bw_n), .oe_n(oe_n), .addr(addr), .dq(dq)
  );

  typedef struct {
    int    op;    // 0 none, 1 read, 2 write
    int    addr;
    int    bw;
    string tag;
  } ent_t;

  ent_t          pq[$];
  logic [DW-1:0] mdl_mem [NW];
  bit            partial [NW];
  logic [DW-1:0] wdata_cur;
  int  b_base, b_cnt, b_op;
  bit  stalled_prev, any_cmd, done;
  int  n_cmp, n_bad, last_addr;

  function automatic ent_t mk(int op, int a, int bw, string t);
    ent_t e;
    e.op = op; e.addr = a; e.bw = bw; e.tag = t;
    return e;
  endfunction

  initial begin
    pq.push_back(mk(0, 0, 3, "R10"));
    pq.push_back(mk(0, 0, 3, "R10"));
    b_base = 0; b_cnt = 0; b_op = 0;
    stalled_prev = 0; any_cmd = 0; done = 0;
    n_cmp = 0; n_bad = 0; last_addr = 0;
  end

  // behavioural reference, advanced on each active edge
  always @(posedge clk) begin
    if (!cke_n) begin
      ent_t s, n;
      int a, op;
      string t;
      s = pq[0];
      if (s.op == 2) begin
        if (!s.bw[0]) mdl_mem[s.addr][8:0]  = wdata_cur[8:0];
        if (!s.bw[1]) mdl_mem[s.addr][17:9] = wdata_cur[17:9];
        partial[s.addr] = (s.bw != 0);
      end
      if (adv) begin
        b_cnt = (b_cnt + 1) & 3;
        a  = (b_base & ~3) | (lin_order ? ((b_base + b_cnt) & 3) : ((b_base ^ b_cnt) & 3));
        op = b_op;
        t  = (op == 0) ? (any_cmd ? "R6" : "R10") : (lin_order ? "R7" : "R8");
      end else if (!ce_a_n && ce_b && !ce_c_n) begin
        b_base = int'(addr); b_cnt = 0;
        op = wr_n ? 1 : 2; a = int'(addr); b_op = op; any_cmd = 1;
        t  = wr_n ? "R2" : "R1";
      end else begin
        op = 0; a = int'(addr); b_op = 0;
        t  = any_cmd ? "R6" : "R10";
      end
      if (op == 1 && pq[1].op == 2 && pq[1].addr == a) t = "R3";
      else if (op == 1 && partial[a] && t == "R2") t = "R4";
      n = mk(op, a, int'(bw_n), t);
      void'(pq.pop_front());
      pq.push_back(n);
      stalled_prev = 0;
    end else begin
      stalled_prev = 1;
    end
  end

  task automatic check_bus();
    ent_t s;
    logic [DW-1:0] exp;
    string t;
    s = pq[0];
    t = s.tag;
    if (s.op == 1 && !oe_n)      exp = mdl_mem[s.addr];
    else if (s.op == 2)          exp = wdata_cur;
    else                         exp = {DW{1'bz}};
    if (s.op != 0 && oe_n)       t = "R5";
    if (stalled_prev)            t = "R9";
    n_cmp++;
    if (dq !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: dq=%h expected %h", t, $time, dq, exp);
    end
  endtask

  // one bus cycle: drive write data for the current slot, compare, set next command
  task automatic step(bit ck, bit ad, bit s, bit w, bit lin, bit [1:0] bw, bit oe, int a);
    @(negedge clk);
    if (!stalled_prev) wdata_cur = DW'($urandom);
    drv_en  = (pq[0].op == 2);
    drv_val = wdata_cur;
    #0.4;
    check_bus();
    cke_n = ck; adv = ad; wr_n = w; lin_order = lin; bw_n = bw; oe_n = oe;
    addr = AW'(a);
    if (s) begin
      ce_a_n = 0; ce_b = 1; ce_c_n = 0;
    end else begin
      int k = $urandom % 3;
      ce_a_n = (k == 0); ce_b = (k != 1); ce_c_n = (k == 2);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; cke_n = 0; ce_a_n = 1; ce_b = 0; ce_c_n = 1; wr_n = 1; adv = 0;
    lin_order = 1; bw_n = 2'b11; oe_n = 0; addr = '0; drv_en = 0; drv_val = '0;
    wdata_cur = '0;
    // R10: reset state, bus idle
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 2'b11, 0, 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, 2'b11, 0, 0);
    // R10: advance before any command does nothing
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 1, 2'b00, 0, 5);
    // R1: fill the array with full writes
    for (int a = 0; a < NW; a++) step(0, 0, 1, 0, 1, 2'b00, 0, a);
    // R2: read some back, R3: write then read same word back to back
    for (int a = 0; a < 8; a++) step(0, 0, 1, 1, 1, 2'b00, 0, a);
    step(0, 0, 1, 0, 1, 2'b00, 0, 9);
    step(0, 0, 1, 1, 1, 2'b00, 0, 9);
    // R4: partial lane writes then reads
    step(0, 0, 1, 0, 1, 2'b10, 0, 12);
    step(0, 0, 1, 1, 1, 2'b00, 0, 12);
    step(0, 0, 1, 0, 1, 2'b01, 0, 13);
    step(0, 0, 0, 1, 1, 2'b00, 0, 0);
    step(0, 0, 1, 1, 1, 2'b00, 0, 13);
    // R7: linear read burst from 1, R8: interleaved read burst from 6
    step(0, 0, 1, 1, 1, 2'b00, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 2'b00, 0, 40);
    step(0, 0, 1, 1, 0, 2'b00, 0, 6);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 2'b00, 0, 40);
    // R7: write burst, then read it back
    step(0, 0, 1, 0, 1, 2'b00, 0, 22);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 1, 2'b00, 0, 0);
    for (int a = 20; a < 24; a++) step(0, 0, 1, 1, 1, 2'b00, 0, a);
    // R9: stall inside a read slot and a write slot
    step(0, 0, 1, 1, 1, 2'b00, 0, 3);
    step(0, 0, 1, 0, 1, 2'b00, 0, 4);
    step(1, 0, 1, 0, 1, 2'b00, 0, 30);
    step(1, 0, 1, 0, 1, 2'b00, 0, 30);
    step(0, 0, 1, 1, 1, 2'b00, 0, 4);
    // R5: output enable high during read, writes unaffected
    step(0, 0, 1, 0, 1, 2'b00, 1, 7);
    step(0, 0, 1, 1, 1, 2'b00, 1, 7);
    step(0, 0, 1, 1, 1, 2'b00, 1, 7);
    step(0, 0, 1, 1, 1, 2'b00, 0, 7);
    // R6: deselect between reads
    step(0, 0, 0, 1, 1, 2'b00, 0, 7);
    step(0, 0, 1, 1, 1, 2'b00, 0, 7);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int a;
      a = ($urandom % 3 == 0) ? last_addr : int'($urandom % NW);
      last_addr = a;
      step(($urandom % 6 == 0), ($urandom % 4 == 0), ($urandom % 7 != 0),
           bit'($urandom % 2), bit'($urandom % 2),
           ($urandom % 2 == 0) ? 2'b00 : 2'($urandom), ($urandom % 10 == 0), a);
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, 2'b11, 0, 0);
    finish_run();
  end

endmodule